// File: doc/BRIEF.md
# Nested Page Table Walker

This block turns a guest-physical address into a host-physical address. It reads a four-level second-stage translation table that lives in ordinary memory. A requester presents one address together with the root pointer of the table hierarchy. The walker then issues one 64-bit entry read per level through a request/response memory port and waits for each reply. It finishes with either a translated address or a fault.

Each level's table is 4 KiB and naturally aligned. An entry address is the 40-bit table base, followed by nine index bits cut from the guest address, followed by three zero bits. The base comes from the root pointer for the first level and from the previous entry for every later level. An entry at the third (directory) level that has its large-page flag set ends the walk early with a 2 MiB page. Otherwise the fourth level supplies a 4 KiB page.

The walker handles one translation at a time. Results are presented for exactly one cycle, marked by a completion strobe.

Top module: `gpa_walker`

## Requirements
- R1: After reset the walker is idle: `req_ready` is 1, and `done` and `mem_req_valid` are 0.
- R2: The first read address has bits 63:52 zero, bits 51:12 equal to `root_ptr[51:12]`, bits 11:3 equal to guest bits 47:39, and bits 2:0 zero. The other bits of `root_ptr` have no effect.
- R3: The second and third reads use bits 51:12 of the previous entry as table base. They are indexed by guest bits 38:30 and 29:21 respectively, and follow the same bit layout as R2.
- R4: When the third-level entry has bit 7 clear, a fourth read is indexed by guest bits 20:12. The result is entry bits 51:12 above guest bits 11:0, with zeros in bits 63:52, `page_2m` = 0 and `fault` = 0.
- R5: When the third-level entry has bit 7 set, the walk ends after three reads. The result is entry bits 51:21 above guest bits 20:0, with `page_2m` = 1.
- R6: An entry with bits 2:0 all zero is not present. The walk ends with `fault` = 1, `fault_level` set to the level of that entry (1 to 4), `result_pa` = 0, and no further reads.
- R7: A guest address with any of bits 63:48 set gives `fault` = 1 and `fault_level` = 0 without any memory read.
- R8: `req_ready` is 1 only while idle. A request presented while a walk is in progress is ignored: it causes neither reads nor a result.
- R9: `done` is high for exactly one cycle per accepted request. The walker is idle again in the following cycle.
- R10: A memory request stays asserted with an unchanged address until `mem_req_ready` is seen. Any number of wait cycles before ready, and before the response, is tolerated.
- R11: Bit 7 has no effect in first-, second- or fourth-level entries. Bits 63:52 of any entry never reach an address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to accept a request |
| req_gpa | input | 64 | Guest-physical address to translate |
| root_ptr | input | 64 | Table root pointer; bits 51:12 give the first-level table base |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory accepts the read request |
| mem_req_addr | output | 64 | Byte address of the 64-bit entry |
| mem_rsp_valid | input | 1 | Read data valid for one cycle |
| mem_rsp_data | input | 64 | Entry read from memory |
| done | output | 1 | One-cycle completion strobe |
| fault | output | 1 | Walk ended in a fault (valid with `done`) |
| fault_level | output | 3 | 0 for an out-of-range address, else the level 1 to 4 of the absent entry |
| result_pa | output | 64 | Host-physical address (valid with `done`, zero on fault) |
| page_2m | output | 1 | Translation is a 2 MiB page |

## Verification
The bench builds the walker with the package defaults: four levels, nine index bits per level, a 52-bit host address and the large-page flag at bit 7 of the third level. These defaults put the top-slot corner (every index 511) in reach, along with faults at each of the four levels and the early stop at the directory level. The memory model's ready and response delays are set from zero up to six cycles. This covers back-to-back handshakes as well as long stalls, during which a competing request is held on the input.

// File: rtl/gw_pkg.sv
`timescale 1ns/1ps
package gw_pkg;
  localparam int WORD_W    = 64;
  localparam int PG_SHIFT  = 12;
  localparam int IDX_W     = 9;
  localparam int LEVELS    = 4;
  localparam int PA_MSB    = 51;
  localparam int GPA_MSB   = 47;
  localparam int BIG_LVL   = 3;
  localparam int BIG_BIT   = 7;
  localparam int PERM_W    = 3;
  localparam int LVL_W     = 3;
  localparam int BIG_SHIFT = PG_SHIFT + IDX_W;
  localparam int BASE_W    = PA_MSB + 1 - PG_SHIFT;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [BASE_W-1:0] base_t;
  typedef logic [IDX_W-1:0]  idx_t;
  typedef logic [LVL_W-1:0]  lvl_t;

  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT, ST_DONE} st_e;

  // Upper guest bits must all be clear for a walk to start.
  function automatic logic gpa_ok(input word_t g);
    return g[WORD_W-1:GPA_MSB+1] == '0;
  endfunction

  // Nine-bit index for a level (1 = top).
  function automatic idx_t slot(input word_t g, input lvl_t l);
    int    sh;
    word_t t;
    sh = PG_SHIFT + IDX_W * (LEVELS - int'(l));
    t  = g >> sh;
    return t[IDX_W-1:0];
  endfunction

  function automatic word_t entry_addr(input base_t b, input idx_t i);
    word_t a;
    a = '0;
    a[PA_MSB:PG_SHIFT]  = b;
    a[PG_SHIFT-1:3]     = i;
    return a;
  endfunction

  function automatic word_t leaf_small(input word_t e, input word_t g);
    word_t a;
    a = '0;
    a[PA_MSB:PG_SHIFT]  = e[PA_MSB:PG_SHIFT];
    a[PG_SHIFT-1:0]     = g[PG_SHIFT-1:0];
    return a;
  endfunction

  function automatic word_t leaf_big(input word_t e, input word_t g);
    word_t a;
    a = '0;
    a[PA_MSB:BIG_SHIFT] = e[PA_MSB:BIG_SHIFT];
    a[BIG_SHIFT-1:0]    = g[BIG_SHIFT-1:0];
    return a;
  endfunction
endpackage

// File: rtl/gw_addr_gen.sv
`timescale 1ns/1ps
module gw_addr_gen
  import gw_pkg::*;
(
  input  base_t base,
  input  word_t gpa,
  input  lvl_t  level,
  output word_t addr
);
  idx_t idx;

  assign idx  = slot(gpa, level);
  assign addr = entry_addr(base, idx);
endmodule

// File: rtl/gw_entry_dec.sv
`timescale 1ns/1ps
module gw_entry_dec
  import gw_pkg::*;
(
  input  word_t entry,
  input  lvl_t  level,
  output logic  present,
  output logic  big_leaf,
  output logic  last_lvl,
  output base_t next_base
);
  logic unused_entry_bits;

  assign present   = |entry[PERM_W-1:0];
  assign big_leaf  = entry[BIG_BIT] && (level == lvl_t'(BIG_LVL));
  assign last_lvl  = level == lvl_t'(LEVELS);
  assign next_base = entry[PA_MSB:PG_SHIFT];
  assign unused_entry_bits = ^{entry[WORD_W-1:PA_MSB+1], entry[PG_SHIFT-1:BIG_BIT+1],
                               entry[BIG_BIT-1:PERM_W]};
endmodule

// File: rtl/gpa_walker.sv
`timescale 1ns/1ps
module gpa_walker
  import gw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [WORD_W-1:0] req_gpa,
  input  logic [WORD_W-1:0] root_ptr,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [WORD_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [WORD_W-1:0] mem_rsp_data,
  output logic              done,
  output logic              fault,
  output logic [LVL_W-1:0]  fault_level,
  output logic [WORD_W-1:0] result_pa,
  output logic              page_2m
);
  st_e   st_q;
  word_t gpa_q, pa_q;
  base_t base_q;
  lvl_t  lvl_q, flvl_q;
  logic  fault_q, big_q;

  // Named events for the checks below.
  logic  accept, in_range, req_fire, rsp_take;
  logic  ent_present, ent_big, ent_last;
  base_t ent_base;
  logic  unused_root_bits;

  assign accept   = req_valid && (st_q == ST_IDLE);
  assign in_range = gpa_ok(req_gpa);
  assign req_fire = mem_req_valid && mem_req_ready;
  assign rsp_take = (st_q == ST_WAIT) && mem_rsp_valid;
  assign unused_root_bits = ^{root_ptr[WORD_W-1:PA_MSB+1], root_ptr[PG_SHIFT-1:0]};

  gw_addr_gen u_addr (
    .base  (base_q),
    .gpa   (gpa_q),
    .level (lvl_q),
    .addr  (mem_req_addr)
  );

  gw_entry_dec u_dec (
    .entry     (mem_rsp_data),
    .level     (lvl_q),
    .present   (ent_present),
    .big_leaf  (ent_big),
    .last_lvl  (ent_last),
    .next_base (ent_base)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      gpa_q   <= '0;
      pa_q    <= '0;
      base_q  <= '0;
      lvl_q   <= '0;
      flvl_q  <= '0;
      fault_q <= 1'b0;
      big_q   <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: if (accept) begin
          gpa_q   <= req_gpa;
          base_q  <= root_ptr[PA_MSB:PG_SHIFT];
          lvl_q   <= lvl_t'(1);
          flvl_q  <= '0;
          pa_q    <= '0;
          big_q   <= 1'b0;
          fault_q <= !in_range;
          st_q    <= in_range ? ST_ISSUE : ST_DONE;
        end
        ST_ISSUE: if (req_fire) st_q <= ST_WAIT;
        ST_WAIT: if (rsp_take) begin
          if (!ent_present) begin
            fault_q <= 1'b1;
            flvl_q  <= lvl_q;
            st_q    <= ST_DONE;
          end else if (ent_big) begin
            pa_q    <= leaf_big(mem_rsp_data, gpa_q);
            big_q   <= 1'b1;
            st_q    <= ST_DONE;
          end else if (ent_last) begin
            pa_q    <= leaf_small(mem_rsp_data, gpa_q);
            st_q    <= ST_DONE;
          end else begin
            base_q  <= ent_base;
            lvl_q   <= lvl_q + lvl_t'(1);
            st_q    <= ST_ISSUE;
          end
        end
        ST_DONE: st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready     = st_q == ST_IDLE;
  assign mem_req_valid = st_q == ST_ISSUE;
  assign done          = st_q == ST_DONE;
  assign fault         = fault_q;
  assign fault_level   = flvl_q;
  assign result_pa     = pa_q;
  assign page_2m       = big_q;

  // R2: entry addresses keep their zero fields
  p_addr_frame_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (mem_req_addr[WORD_W-1:PA_MSB+1] == '0) && (mem_req_addr[2:0] == '0));

  // R5: a large page can only end the walk at the directory level
  p_big_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && page_2m) |-> (!fault && lvl_q == lvl_t'(BIG_LVL)));

  // R6: an absent entry stops the walk at its own level
  p_absent_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_take && !ent_present) |=> (done && fault && fault_level == $past(lvl_q)));

  // R7: out-of-range address faults at once with no read
  p_range_fault_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !in_range) |=> (done && fault && fault_level == '0 && !mem_req_valid));

  // R8: no acceptance while a read is pending
  p_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid || st_q == ST_WAIT) |-> !req_ready);

  // R9: completion strobe lasts one cycle
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && req_ready));

  // R10: a stalled request holds its address
  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));
endmodule

// File: tb/gpa_walker_bench.sv
`timescale 1ns/1ps
module gpa_walker_bench;
  logic        clk, rst_n;
  logic        req_valid, req_ready;
  logic [63:0] req_gpa, root_ptr;
  logic        mem_req_valid, mem_req_ready;
  logic [63:0] mem_req_addr;
  logic        mem_rsp_valid;
  logic [63:0] mem_rsp_data;
  logic        done, fault, page_2m;
  logic [2:0]  fault_level;
  logic [63:0] result_pa;

  gpa_walker u_gpa_walker (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_gpa(req_gpa), .root_ptr(root_ptr),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .done(done), .fault(fault), .fault_level(fault_level),
    .result_pa(result_pa), .page_2m(page_2m)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  localparam longint unsigned ROOT_PG  = 64'h10000;
  localparam longint unsigned PGM      = (64'h1 << 40) - 1;
  localparam longint unsigned PAM      = (64'h1 << 52) - 1;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;

  logic [63:0] mem [logic [63:0]];
  longint unsigned exp_q[$];
  longint unsigned tbl_next = 64'h20000;
  bit          exp_fault, exp_big, walk_open, idle_m, after_done;
  int          exp_lvl, rd_idx, g_rdy_wait, g_rsp_wait;
  logic [63:0] exp_pa;
  string       exp_tag;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  function automatic logic [63:0] rd(input logic [63:0] a);
    return mem.exists(a) ? mem[a] : 64'h0;
  endfunction

  function automatic longint unsigned ix(input longint unsigned g, input int lvl);
    return (g >> (39 - 9 * (lvl - 1))) % 512;
  endfunction

  function automatic longint unsigned tbl_addr(input longint unsigned pg, input longint unsigned i);
    return pg * 4096 + i * 8;
  endfunction

  // Build the table chain for one page; intermediate entries carry junk bits.
  task automatic map_page(input longint unsigned g, input longint unsigned pa,
                          input bit big, input bit junk7);
    longint unsigned pg, a;
    int last;
    pg = ROOT_PG;
    last = big ? 3 : 4;
    for (int l = 1; l <= last; l++) begin
      a = tbl_addr(pg, ix(g, l));
      if (l == last) begin
        if (big) mem[a] = ((pa >> 21) << 21) | 64'h85 | 64'h2000_0000_0000_0000;
        else     mem[a] = ((pa >> 12) << 12) | 64'h3 | (junk7 ? 64'h80 : 64'h0)
                          | 64'h2000_0000_0000_0000;
      end else begin
        if (!mem.exists(a)) begin
          mem[a] = (tbl_next << 12) | 64'h907 | ((junk7 && l < 3) ? 64'h80 : 64'h0)
                   | 64'h1000_0000_0000_0000;
          tbl_next++;
        end
        pg = (mem[a] >> 12) & PGM;
      end
    end
  endtask

  task automatic clear_present(input longint unsigned g, input int lvl);
    longint unsigned pg, a;
    pg = ROOT_PG;
    for (int l = 1; l <= lvl; l++) begin
      a = tbl_addr(pg, ix(g, l));
      if (l == lvl) mem[a] = mem[a] & ~64'h7;
      else pg = (rd(a) >> 12) & PGM;
    end
  endtask

  // Reference walk over the bench memory.
  task automatic model(input longint unsigned g);
    longint unsigned pg, a;
    logic [63:0] e;
    exp_fault = 0; exp_big = 0; exp_lvl = 0; exp_pa = 0;
    if ((g >> 48) != 0) begin exp_fault = 1; return; end
    pg = ROOT_PG;
    for (int l = 1; l <= 4; l++) begin
      a = tbl_addr(pg, ix(g, l));
      exp_q.push_back(a);
      e = rd(a);
      if ((e & 64'h7) == 0) begin exp_fault = 1; exp_lvl = l; return; end
      if (l == 3 && e[7]) begin
        exp_big = 1;
        exp_pa = (((e & PAM) >> 21) << 21) | (g & ((64'h1 << 21) - 1));
        return;
      end
      if (l == 4) begin
        exp_pa = (((e & PAM) >> 12) << 12) | (g & 64'hfff);
        return;
      end
      pg = (e >> 12) & PGM;
    end
  endtask

  task automatic launch(input longint unsigned g, input string tag, input int spurious);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    model(g);
    exp_tag = tag;
    rd_idx = 0;
    walk_open = 1;
    req_gpa = g;
    req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    req_gpa = 64'hDEAD_0000_0000_0000;
    // R8: competing request held while busy
    for (int k = 0; k < spurious; k++) begin
      req_gpa = 64'h0000_8000_0000_0000;
      req_valid = 1;
      @(negedge clk);
    end
    req_valid = 0;
    while (walk_open) @(negedge clk);
  endtask

  // Memory responder
  initial begin
    bit rsp_pend, last_wait;
    int rdy_cnt, rsp_cnt;
    logic [63:0] cap_addr, last_addr;
    string t;
    rsp_pend = 0; last_wait = 0; rdy_cnt = -1; rsp_cnt = 0;
    cap_addr = 0; last_addr = 0;
    mem_req_ready = 0; mem_rsp_valid = 0; mem_rsp_data = 0;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 0;
      if (rst_n) begin
        if (mem_req_ready) begin
          mem_req_ready = 0;
          rsp_pend = 1;
          rsp_cnt = g_rsp_wait;
          rdy_cnt = -1;
        end else if (mem_req_valid && !rsp_pend) begin
          if (last_wait) chk(mem_req_addr == last_addr, "R10", "stalled address", mem_req_addr, last_addr);
          if (rdy_cnt < 0) rdy_cnt = g_rdy_wait;
          if (rdy_cnt == 0) begin
            mem_req_ready = 1;
            rd_idx++;
            t = (rd_idx == 1) ? "R2" : (rd_idx == 4) ? "R4" : "R3";
            if (exp_q.size() == 0) chk(0, "R6", "unexpected read", mem_req_addr, 0);
            else begin
              longint unsigned ea;
              ea = exp_q.pop_front();
              chk(mem_req_addr == ea, t, "entry address", mem_req_addr, ea);
            end
            cap_addr = mem_req_addr;
            last_wait = 0;
          end else begin
            rdy_cnt--;
            last_wait = 1;
            last_addr = mem_req_addr;
          end
        end
        if (rsp_pend) begin
          if (rsp_cnt == 0) begin
            mem_rsp_valid = 1;
            mem_rsp_data = rd(cap_addr);
            rsp_pend = 0;
          end else rsp_cnt--;
        end
      end
    end
  end

  // Per-clock comparison against the behavioural model
  initial begin
    idle_m = 1; after_done = 0; walk_open = 0;
    forever begin
      @(posedge clk);
      #1;
      if (rst_n && !finished) begin
        if (after_done) begin
          chk(!done, "R9", "strobe length", {63'b0, done}, 0);
          idle_m = 1;
          after_done = 0;
        end else if (idle_m && req_valid) idle_m = 0;
        chk(req_ready == idle_m, "R8", "ready vs idle", {63'b0, req_ready}, {63'b0, idle_m});
        if (done) begin
          chk(walk_open, "R9", "done without request", 1, 0);
          chk(fault == exp_fault, exp_tag, "fault", {63'b0, fault}, {63'b0, exp_fault});
          chk(fault_level == 3'(exp_lvl), exp_tag, "fault_level", {61'b0, fault_level}, 64'(exp_lvl));
          chk(result_pa == exp_pa, exp_tag, "result_pa", result_pa, exp_pa);
          chk(page_2m == exp_big, exp_tag, "page_2m", {63'b0, page_2m}, {63'b0, exp_big});
          chk(exp_q.size() == 0, exp_tag, "reads left", 64'(exp_q.size()), 0);
          walk_open = 0;
          after_done = 1;
        end
      end
    end
  end

  initial begin
    #(4 * 100000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual=hung expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 0; req_valid = 0; req_gpa = 0;
    g_rdy_wait = 0; g_rsp_wait = 0;
    root_ptr = (64'hABC << 52) | (ROOT_PG << 12) | 64'h5A5;
    map_page(64'h0000_1234_5678_9ABC, 64'h000F_EDCB_A987_6000, 0, 0);
    map_page(64'h0000_0040_0030_5555, 64'h000A_BCDE_0020_0000, 1, 0);
    map_page(64'h0000_FFFF_FFFF_FFFF, 64'h000A_0000_1234_5000, 0, 1);
    map_page(64'h0000_2000_0000_1000, 64'h0000_0000_7777_7000, 0, 0);
    map_page(64'h0000_3000_4000_0000, 64'h0000_0000_6666_6000, 0, 0);
    map_page(64'h0000_3800_0000_0000, 64'h0000_0000_5555_5000, 0, 0);
    clear_present(64'h0000_2000_0000_1000, 4);
    clear_present(64'h0000_3000_4000_0000, 2);
    clear_present(64'h0000_3800_0000_0000, 3);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: idle after reset
    chk(req_ready == 1, "R1", "req_ready", {63'b0, req_ready}, 1);
    chk(done == 0, "R1", "done", {63'b0, done}, 0);
    chk(mem_req_valid == 0, "R1", "mem_req_valid", {63'b0, mem_req_valid}, 0);

    launch(64'h0000_1234_5678_9ABC, "R4", 0);
    g_rdy_wait = 2; g_rsp_wait = 3;
    launch(64'h0000_0040_0030_5555, "R5", 0);
    g_rdy_wait = 1; g_rsp_wait = 0;
    launch(64'h0000_FFFF_FFFF_FFFF, "R11", 0);
    g_rdy_wait = 0; g_rsp_wait = 1;
    launch(64'h0000_8000_0000_0000, "R6", 0);
    launch(64'h0000_2000_0000_1000, "R6", 0);
    launch(64'h0000_3000_4000_0000, "R6", 0);
    launch(64'h0000_3800_0000_0000, "R6", 0);
    launch(64'h0001_0000_0000_0000, "R7", 0);
    launch(64'h8000_0000_0000_0000, "R7", 0);
    g_rdy_wait = 4; g_rsp_wait = 6;
    launch(64'h0000_1234_5678_9ABC, "R8", 3);
    g_rdy_wait = 0; g_rsp_wait = 5;
    launch(64'h0000_0040_0030_5555, "R10", 0);
    g_rdy_wait = 6; g_rsp_wait = 0;
    launch(64'h0000_FFFF_FFFF_F123, "R10", 0);
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R8", "no stray reads", 64'(exp_q.size()), 0);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule